// File: doc/BRIEF.md
# External Sample Trigger Qualifier

This block turns a shared pin into a checked sampling trigger. While the trigger enable is low, the pin is an interrupt output and the block asks for the output driver. While the enable is high, the driver is released and the pin is read as an active-high trigger. The raw level is passed through a two-flop synchronizer. Counters then measure the low phase before each rising edge, the high phase after it, and the time since the last accepted trigger. Each valid trigger produces exactly one clock-wide sample-start strobe.

A trigger that breaks a timing rule produces no strobe. It sets a sticky violation flag instead, and software clears that flag with a one-cycle read strobe. Minimum durations are given in nanoseconds. The cycle limits are derived from the clock frequency parameter. With the defaults (100 MHz, 25 µs high, 25 µs low, 1.6 ms spacing), the limits are 2500, 2500 and 160000 cycles. The trigger has no minimum rate. The strobe and the flag are plain control signals: they carry no data, so there is no valid/ready handshake and no back-pressure.

Top module: `ext_trig_qual`

## Requirements
- R1: After reset, `sample_stb` and `viol_flag` are 0.
- R2: `pin_oe` is 1 exactly while `trig_en` is 0. While the trigger is disabled, pin activity produces no strobe and leaves `viol_flag` unchanged.
- R3: A rising edge that qualifies, followed by a high phase of at least HI_CYC cycles, gives a one-cycle `sample_stb`. The strobe comes after the (HI_CYC+2)-th rising clock edge, counting from the first edge that samples the pin high. HI_CYC = CLK_HZ*HI_MIN_NS/10^9, rounded down; LO_CYC and PER_CYC are derived the same way.
- R4: A high phase that qualified at its rising edge but lasts fewer than HI_CYC cycles gives no strobe and sets `viol_flag`.
- R5: A rising edge that follows fewer than LO_CYC consecutive low cycles is rejected: it gives no strobe however long the pin stays high, and it sets `viol_flag`. Low time is counted only while enabled, so a pin that is already high when the trigger is enabled is rejected.
- R6: A rising edge that comes fewer than PER_CYC cycles after the previous qualifying rising edge is rejected, with no strobe, and sets `viol_flag`. A qualifying edge is one that passed both the low-time check and the spacing check.
- R7: Each pulse gives at most one strobe, however long it stays high. Strobes are never closer than PER_CYC cycles apart.
- R8: `viol_flag` stays set until a cycle with `viol_rd` high, and it reads 0 after that edge. If a new violation arrives in the same cycle as the read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_en | input | 1 | 1: pin is a trigger input; 0: pin is an interrupt output |
| trig_pin | input | 1 | Raw, asynchronous pin level |
| viol_rd | input | 1 | One-cycle read strobe that clears the violation flag |
| sample_stb | output | 1 | One-cycle sample-start pulse |
| viol_flag | output | 1 | Sticky timing-violation flag |
| pin_oe | output | 1 | Output enable for the pin's interrupt driver |

## Verification
The checker watches four things on every cycle:
- a strobe is always a single cycle;
- no strobe follows a cycle with the trigger disabled;
- strobes keep the minimum spacing;
- the violation flag never drops without a read.

Whether a particular pulse should have been accepted is shown only by the bench's sweeps. These vary the low time, the high width and the gap across the boundary values, checking strobe timing to the cycle and the flag after every pulse. The bench scenarios also cover the pin being high at enable and a violation that lands in the same cycle as a read.

// File: rtl/ext_trig_qual_pkg.sv
package ext_trig_qual_pkg;

  // Phase of the synchronized trigger as seen by the qualifier.
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,  // waiting for a rising edge
    PH_PEND = 2'd1,  // accepted edge, high phase not yet long enough
    PH_HOLD = 2'd2   // strobe issued or edge rejected; wait for low
  } phase_t;

  // Whole clock cycles in a duration given in nanoseconds (rounded down).
  function automatic int ns_to_cyc(longint hz, longint ns);
    return int'((hz * ns) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/etq_sync.sv
module etq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)   chain[0] <= 1'b0;
          else if (clr) chain[0] <= 1'b0;
          else          chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)   chain[i] <= 1'b0;
          else if (clr) chain[i] <= 1'b0;
          else          chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/etq_sat_ctr.sv
module etq_sat_ctr #(
  parameter int MAX      = 4,
  parameter bit RST_FULL = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill,     // jump to MAX
  input  logic                       clr,      // jump to 0
  input  logic                       restart,  // jump to 1
  output logic [$clog2(MAX+1)-1:0]   cnt,
  output logic                       at_max
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] MAXV = W'(MAX);
  localparam logic [W-1:0] ONE  = W'(1);

  assign at_max = (cnt == MAXV);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= RST_FULL ? MAXV : '0;
    else if (fill)    cnt <= MAXV;
    else if (clr)     cnt <= '0;
    else if (restart) cnt <= ONE;
    else if (!at_max) cnt <= cnt + ONE;
endmodule

// File: rtl/ext_trig_qual.sv
module ext_trig_qual
  import ext_trig_qual_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int HI_MIN_NS  = 25_000,
  parameter int LO_MIN_NS  = 25_000,
  parameter int PER_MIN_NS = 1_600_000,
  parameter int SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_en,
  input  logic trig_pin,
  input  logic viol_rd,
  output logic sample_stb,
  output logic viol_flag,
  output logic pin_oe
);
  // HI_CYC must be at least 2 and LO_CYC at least 1 for the phase logic below.
  localparam int HI_CYC  = ns_to_cyc(CLK_HZ, HI_MIN_NS);
  localparam int LO_CYC  = ns_to_cyc(CLK_HZ, LO_MIN_NS);
  localparam int PER_CYC = ns_to_cyc(CLK_HZ, PER_MIN_NS);
  localparam int HW      = $clog2(HI_CYC + 1);
  localparam int LW      = $clog2(LO_CYC + 1);
  localparam int PW      = $clog2(PER_CYC + 1);
  localparam logic [HW-1:0] HI_LAST = HW'(HI_CYC - 1);

  // R2: the interrupt driver is released whenever the pin is a trigger input.
  assign pin_oe = ~trig_en;

  logic lvl, lvl_d;
  etq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(~trig_en), .d(trig_pin), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lvl_d <= 1'b0;
    else if (!trig_en) lvl_d <= 1'b0;
    else               lvl_d <= lvl;

  logic rise;
  assign rise = lvl & ~lvl_d;

  // Counts cycles the synchronized level has been high before this cycle.
  logic [HW-1:0] hi_cnt;
  logic          hi_full;
  etq_sat_ctr #(.MAX(HI_CYC), .RST_FULL(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_n), .fill(1'b0), .clr(~lvl | ~trig_en),
    .restart(1'b0), .cnt(hi_cnt), .at_max(hi_full)
  );

  // Counts consecutive low cycles seen while enabled (R5).
  logic [LW-1:0] lo_cnt;
  logic          lo_ok;
  etq_sat_ctr #(.MAX(LO_CYC), .RST_FULL(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .fill(1'b0), .clr(lvl | ~trig_en),
    .restart(1'b0), .cnt(lo_cnt), .at_max(lo_ok)
  );

  // Distance from the last qualifying rising edge (R6). Full when none.
  logic          edge_ok;
  logic [PW-1:0] per_cnt;
  logic          per_ok;
  etq_sat_ctr #(.MAX(PER_CYC), .RST_FULL(1'b1)) u_per (
    .clk(clk), .rst_n(rst_n), .fill(~trig_en), .clr(1'b0),
    .restart(edge_ok), .cnt(per_cnt), .at_max(per_ok)
  );

  assign edge_ok = trig_en & rise & lo_ok & per_ok;

  phase_t ph, ph_nx;
  logic   stb_set, viol_set;

  always_comb begin
    ph_nx    = ph;
    stb_set  = 1'b0;
    viol_set = 1'b0;
    unique case (ph)
      PH_LOW: if (rise) begin
        if (edge_ok) ph_nx = PH_PEND;
        else begin
          ph_nx    = PH_HOLD;   // R5 / R6 rejection
          viol_set = 1'b1;
        end
      end
      PH_PEND: if (!lvl) begin
        ph_nx    = PH_LOW;      // R4 high phase too short
        viol_set = 1'b1;
      end else if (hi_cnt == HI_LAST) begin
        ph_nx   = PH_HOLD;      // R3 width reached, R7 once only
        stb_set = 1'b1;
      end
      PH_HOLD: if (!lvl) ph_nx = PH_LOW;
      default: ph_nx = PH_LOW;
    endcase
    if (!trig_en) begin
      ph_nx    = PH_LOW;
      stb_set  = 1'b0;
      viol_set = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph         <= PH_LOW;
      sample_stb <= 1'b0;
      viol_flag  <= 1'b0;
    end else begin
      ph         <= ph_nx;
      sample_stb <= stb_set;
      // R8: a new violation wins over a read in the same cycle.
      if (viol_set)     viol_flag <= 1'b1;
      else if (viol_rd) viol_flag <= 1'b0;
    end

  logic unused_ok;
  assign unused_ok = ^{hi_full, lo_cnt, per_cnt};
endmodule

// File: rtl/ext_trig_qual_chk.sv
module ext_trig_qual_chk #(
  parameter int PER_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic trig_en,
  input logic viol_rd,
  input logic sample_stb,
  input logic viol_flag
);
  localparam int GW = $clog2(PER_CYC + 1);
  localparam logic [GW-1:0] GMAX = GW'(PER_CYC);

  // Cycles since the last strobe, full after reset or while disabled.
  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          gap <= GMAX;
    else if (!trig_en)   gap <= GMAX;
    else if (sample_stb) gap <= GW'(1);
    else if (gap != GMAX) gap <= gap + GW'(1);

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (gap == GMAX));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en |=> !sample_stb);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_rd) |=> viol_flag);
endmodule

bind ext_trig_qual ext_trig_qual_chk #(.PER_CYC(PER_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .viol_rd(viol_rd),
  .sample_stb(sample_stb), .viol_flag(viol_flag)
);

// File: tb/ext_trig_qual_bench.sv
`timescale 1ns/1ps
module ext_trig_qual_bench;
  localparam int CLK_HZ = 200_000_000;
  localparam int HI_NS  = 40;
  localparam int LO_NS  = 60;
  localparam int PER_NS = 250;
  localparam int HI  = (CLK_HZ / 1_000_000) * HI_NS / 1000;   // 8
  localparam int LO  = (CLK_HZ / 1_000_000) * LO_NS / 1000;   // 12
  localparam int PER = (CLK_HZ / 1_000_000) * PER_NS / 1000;  // 50

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, pin = 1'b0, rd = 1'b0;
  logic stb, viol, oe;

  ext_trig_qual #(.CLK_HZ(CLK_HZ), .HI_MIN_NS(HI_NS), .LO_MIN_NS(LO_NS),
                  .PER_MIN_NS(PER_NS)) u_ext_trig_qual (
    .clk(clk), .rst_n(rst_n), .trig_en(en), .trig_pin(pin), .viol_rd(rd),
    .sample_stb(stb), .viol_flag(viol), .pin_oe(oe)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model of the trigger rules, driven from the pin stimulus.
  bit    en_m = 1'b0, prev = 1'b0, cur_ok = 1'b0, no_acc = 1'b1, exp_viol = 1'b0;
  int    lo_m = 0, hcount = 0, last_acc = 0, exp_at = -1, exp_cnt = 0, seen_cnt = 0;
  string why = "R1 idle";

  task automatic drive(bit v);
    @(negedge clk);
    pin = v;
    if (!en_m) begin
      prev = v; lo_m = 0; cur_ok = 1'b0;
      return;
    end
    if (v && !prev) begin
      cur_ok = (lo_m >= LO) && (no_acc || (cyc - last_acc) >= PER);
      hcount = 0;
      if (cur_ok) begin
        last_acc = cyc; no_acc = 1'b0; why = "R3 accepted";
      end else begin
        exp_viol = 1'b1;
        why = (lo_m < LO) ? "R5 low phase short" : "R6 spacing short";
      end
    end
    if (v) begin
      hcount++;
      lo_m = 0;
      if (cur_ok && hcount == HI) begin
        exp_at = cyc + 3;
        exp_cnt++;
      end
    end else begin
      if (prev && cur_ok && hcount < HI) begin
        exp_viol = 1'b1; why = "R4 high phase short";
      end
      if (prev) cur_ok = 1'b0;
      lo_m++;
    end
    prev = v;
  endtask

  task automatic set_en(bit b);
    @(negedge clk);
    en = b; en_m = b;
    if (b) begin
      lo_m = 0; no_acc = 1'b1; hcount = 0; cur_ok = 1'b0;
      if (pin) begin
        exp_viol = 1'b1; why = "R5 high at enable";
      end
      prev = pin;
    end
  endtask

  // Settle, compare the flag, then read-clear it (R8).
  task automatic checkpoint();
    repeat (6) drive(1'b0);
    #1 check(why, viol, exp_viol);
    drive(1'b0);
    rd = 1'b1;
    drive(1'b0);
    rd = 1'b0;
    #1 check("R8 cleared by read", viol, 0);
    exp_viol = 1'b0;
  endtask

  task automatic pulse(int l, int h);
    repeat (l) drive(1'b0);
    repeat (h) drive(1'b1);
    drive(1'b0);
  endtask

  // Strobe monitor: exact cycle of every strobe (R3, R7).
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      check("R3/R7 strobe timing", int'(stb), int'(cyc == exp_at));
      if (stb) seen_cnt++;
    end
  end

  initial begin
    repeat (100_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 strobe after reset", stb, 0);
    check("R1 flag after reset", viol, 0);
    check("R2 oe while disabled", oe, 1);

    // R2: pulses while disabled are ignored.
    pulse(20, 30);
    pulse(3, 2);
    #1 check("R2 no flag while disabled", viol, 0);

    set_en(1'b1);
    #1 check("R2 oe released when enabled", oe, 0);
    repeat (20) drive(1'b0);

    // Sweep: low time, high width and pad across the boundaries (R3-R6).
    for (int p = 0; p < 2; p++)
      for (int l = 0; l <= 8; l++)
        for (int h = HI - 3; h <= HI + 3; h++) begin
          repeat (p * 40) drive(1'b0);
          pulse(l, h);
          checkpoint();
        end

    // R6: rise-to-rise distance exactly PER-1 and PER.
    for (int d = PER - 1; d <= PER; d++) begin
      repeat (PER) drive(1'b0);
      pulse(0, HI);
      checkpoint();
      pulse(d - HI - 9, HI);
      checkpoint();
    end

    // R7: a very long high gives one strobe.
    repeat (PER) drive(1'b0);
    pulse(0, 5 * HI);
    checkpoint();

    // R8: violation in the same cycle as a read keeps the flag set.
    drive(1'b1);
    drive(1'b1);
    drive(1'b1);
    rd = 1'b1;
    drive(1'b1);
    rd = 1'b0;
    #1 check("R8 set wins over read", viol, 1);
    drive(1'b0);
    checkpoint();

    // R5: pin already high when enabled is rejected.
    set_en(1'b0);
    repeat (4) drive(1'b1);
    set_en(1'b1);
    repeat (3 * HI) drive(1'b1);
    drive(1'b0);
    checkpoint();

    // Re-enabled path still accepts a clean pulse (R3).
    repeat (PER) drive(1'b0);
    pulse(0, HI + 1);
    checkpoint();

    check("R7 total strobe count", seen_cnt, exp_cnt);
    done = 1'b1;
    finish_run();
  end
endmodule